// File: doc/BRIEF.md
# Envelope-Addressed Complex-Gain Predistorter

This block linearises a transmit chain by multiplying each complex baseband sample by a complex gain picked from a table. The envelope of the sample, the integer square root of I² + Q², selects the table entry, so every amplitude band gets its own gain and phase correction. The forward path is a three-stage pipeline: envelope and address, table read, then complex multiply with rounding toward minus infinity and saturation.

A second table port adapts the entries while the forward path keeps running. When an update is requested, the entry is moved against two error terms that an external feedback estimator supplies. One error term acts on the real (scale) part and the other on the imaginary (rotation) part. Each error is scaled by a power-of-two step size. The update targets the address that the forward path used a programmable number of cycles earlier, which lines the correction up with the loop delay of the amplifier and the feedback receiver.

Top module: `lut_predistorter`

## Requirements
- R1: While reset is asserted and after it, out_valid is 0 and out_i/out_q are 0. Every one of the 128 table entries starts as the unity gain, real part 2047 and imaginary part 0.
- R2: The table address is floor(sqrt(I² + Q²)) shifted right by 5, with I and Q read as 12-bit two's-complement values. The magnitude never exceeds 2896, so the address stays within 0..90.
- R3: For a sample accepted with in_valid high at clock edge k, out_valid is 1 after edge k+2 and 0 after edge k+1. The outputs are out_i = sat((I·Gr − Q·Gi) >>> 11) and out_q = sat((I·Gi + Q·Gr) >>> 11), where sat clips to −2048..2047. The outputs hold their previous values whenever no result is produced.
- R4: When upd_en is high at an edge, the selected entry becomes Gr − (err_scale >>> mu_shift) and Gi − (err_rot >>> mu_shift). The shifts are arithmetic and mu_shift is read as unsigned.
- R5: The address captured from the inputs at every edge, whether or not in_valid is high, enters a delay line. An update applied at edge k+1+loop_dly writes the address captured at edge k, for loop_dly in 0..63.
- R6: If an update and a forward read hit the same entry at the same edge, the forward result uses the entry's value from before the update. The next read returns the updated value.
- R7: With upd_en low, no table entry changes, whatever values the error inputs carry.
- R8: Each updated part saturates to −2048..2047 instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_i | input | 12 | Input in-phase sample, signed |
| in_q | input | 12 | Input quadrature sample, signed |
| out_valid | output | 1 | Output sample qualifier |
| out_i | output | 12 | Predistorted in-phase sample, signed |
| out_q | output | 12 | Predistorted quadrature sample, signed |
| upd_en | input | 1 | Apply one coefficient update this edge |
| err_scale | input | 12 | Scale (real part) error, signed |
| err_rot | input | 12 | Rotation (imaginary part) error, signed |
| mu_shift | input | 4 | Step size as a right-shift count |
| loop_dly | input | 6 | Loop delay in cycles for the update address |

## Verification
The forward path is tried with real-only samples, with mixed-sign complex samples, and with samples that sit just below and just above a 32-unit magnitude boundary, both on an axis and off it. Comparing these separates a wrong envelope or address from a wrong multiply or wrong sign. Before these reads, single entries are given distinct gains, so each read shows which entry was selected and whether neighbouring entries stayed unity. Updates are placed at delays of 0, 5 and 63 cycles with zero-magnitude samples between them, so an off-by-one in the delay line writes entry 0, and a later read of entry 0 catches it. Repeated full-scale updates, a full-scale input, an update colliding with a read of the same entry, and an update with upd_en low cover saturation, read-before-write ordering and the idle case.

// File: rtl/lut_predistorter.sv
module lut_predistorter #(
  parameter int DW  = 12,
  parameter int AW  = 7,
  parameter int DLW = 6,
  parameter int SHW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q,
  input  logic                 upd_en,
  input  logic signed [DW-1:0] err_scale,
  input  logic signed [DW-1:0] err_rot,
  input  logic [SHW-1:0]       mu_shift,
  input  logic [DLW-1:0]       loop_dly
);
  localparam int DEPTH = 1 << AW;
  localparam int TAPS  = 1 << DLW;
  localparam int PW    = 2 * DW + 1;
  localparam logic signed [PW-1:0] HI = PW'((1 << (DW - 1)) - 1);
  localparam logic signed [PW-1:0] LO = -HI - PW'(1);
  localparam logic signed [DW-1:0] UNITY = DW'((1 << (DW - 1)) - 1);

  function automatic logic [DW-1:0] isqrt(input logic [2*DW-1:0] v);
    logic [DW-1:0]   r, tr;
    logic [2*DW-1:0] sq;
    r = '0;
    for (int b = DW - 1; b >= 0; b--) begin
      tr = r | (DW'(1) << b);
      sq = {{DW{1'b0}}, tr} * {{DW{1'b0}}, tr};
      if (sq <= v) r = tr;
    end
    return r;
  endfunction

  function automatic logic signed [DW-1:0] sat(input logic signed [PW-1:0] x);
    if (x > HI) return HI[DW-1:0];
    if (x < LO) return LO[DW-1:0];
    return x[DW-1:0];
  endfunction

  logic signed [DW-1:0] tbl_r [DEPTH];
  logic signed [DW-1:0] tbl_i [DEPTH];

  logic signed [PW-1:0] pw;
  logic [DW-1:0]        mag;
  logic [AW-1:0]        addr_c, a1;
  assign pw     = in_i * in_i + in_q * in_q;
  assign mag    = isqrt(pw[2*DW-1:0]);
  assign addr_c = mag[DW-1 -: AW];

  logic [AW-1:0] hist [TAPS-1];
  logic [AW-1:0] taps [TAPS];
  assign taps[0] = a1;
  for (genvar k = 1; k < TAPS; k++) begin : g_tap
    assign taps[k] = hist[k-1];
  end

  logic                 v1, v2;
  logic signed [DW-1:0] s1_i, s1_q, s2_i, s2_q, g_r, g_i;
  logic signed [PW-1:0] p_i, p_q;
  assign p_i = (s2_i * g_r - s2_q * g_i) >>> (DW - 1);
  assign p_q = (s2_i * g_i + s2_q * g_r) >>> (DW - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; v2 <= 1'b0; out_valid <= 1'b0;
      a1 <= '0;
      s1_i <= '0; s1_q <= '0; s2_i <= '0; s2_q <= '0;
      g_r <= '0; g_i <= '0; out_i <= '0; out_q <= '0;
      for (int k = 0; k < TAPS - 1; k++) hist[k] <= '0;
    end else begin
      v1 <= in_valid;
      v2 <= v1;
      out_valid <= v2;
      a1 <= addr_c;
      hist[0] <= a1;
      for (int k = 1; k < TAPS - 1; k++) hist[k] <= hist[k-1];
      if (in_valid) begin
        s1_i <= in_i;
        s1_q <= in_q;
      end
      if (v1) begin
        s2_i <= s1_i;
        s2_q <= s1_q;
        g_r  <= tbl_r[a1];
        g_i  <= tbl_i[a1];
      end
      if (v2) begin
        out_i <= sat(p_i);
        out_q <= sat(p_q);
      end
    end
  end

  logic [AW-1:0]        upd_addr;
  logic signed [DW-1:0] d_r, d_i;
  logic signed [PW-1:0] n_r, n_i;
  assign upd_addr = taps[loop_dly];
  assign d_r = err_scale >>> mu_shift;
  assign d_i = err_rot >>> mu_shift;
  assign n_r = PW'(tbl_r[upd_addr]) - PW'(d_r);
  assign n_i = PW'(tbl_i[upd_addr]) - PW'(d_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) begin
        tbl_r[k] <= UNITY;
        tbl_i[k] <= '0;
      end
    end else if (upd_en) begin
      tbl_r[upd_addr] <= sat(n_r);
      tbl_i[upd_addr] <= sat(n_i);
    end
  end
endmodule

module lut_predistorter_chk #(
  parameter int DW = 12,
  parameter int AW = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_i,
  input logic signed [DW-1:0] out_q,
  input logic [AW-1:0]        addr
);
  localparam int MAXMAG = ((2 ** (DW - 1)) * 181) / 128 + 1;
  localparam int MAXA   = MAXMAG >> (DW - AW);

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(addr) <= MAXA);

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n, 3) |-> out_valid == $past(in_valid, 3));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 3) && !$past(in_valid, 3)) |-> ($stable(out_i) && $stable(out_q)));
endmodule

bind lut_predistorter lut_predistorter_chk #(.DW(DW), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .out_i(out_i), .out_q(out_q), .addr(a1)
);

// File: tb/lut_predistorter_tb.sv
module lut_predistorter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [11:0] in_i = '0, in_q = '0;
  logic out_valid;
  logic signed [11:0] out_i, out_q;
  logic upd_en = 1'b0;
  logic signed [11:0] err_scale = '0, err_rot = '0;
  logic [3:0] mu_shift = '0;
  logic [5:0] loop_dly = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int mr [128];
  int mi [128];

  always #(CLK_PERIOD / 2) clk = ~clk;

  lut_predistorter dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .upd_en(upd_en),
    .err_scale(err_scale), .err_rot(err_rot), .mu_shift(mu_shift), .loop_dly(loop_dly)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int isq(int s);
    int r = 0;
    for (int m = 0; m <= 4096; m++) if (m * m <= s) r = m;
    return r;
  endfunction

  function automatic int sat(int x);
    if (x > 2047) return 2047;
    if (x < -2048) return -2048;
    return x;
  endfunction

  function automatic int addr_of(int i, int q);
    return isq(i * i + q * q) >>> 5;
  endfunction

  task automatic fwd(int i, int q, string tag);
    int a = addr_of(i, q);
    int ei = sat((i * mr[a] - q * mi[a]) >>> 11);
    int eq = sat((i * mi[a] + q * mr[a]) >>> 11);
    in_valid = 1'b1; in_i = 12'(i); in_q = 12'(q);
    @(posedge clk); #1;
    in_valid = 1'b0; in_i = '0; in_q = '0;
    @(posedge clk); #1;
    chk({tag, " R3 valid not early"}, int'(out_valid), 0);
    @(posedge clk); #1;
    chk({tag, " R3 valid"}, int'(out_valid), 1);
    chk({tag, " out_i"}, int'(out_i), ei);
    chk({tag, " out_q"}, int'(out_q), eq);
  endtask

  task automatic upd(int i, int q, int d, int es, int er, int sh, bit en);
    int a = addr_of(i, q);
    loop_dly = 6'(d); mu_shift = 4'(sh);
    err_scale = 12'(es); err_rot = 12'(er);
    in_i = 12'(i); in_q = 12'(q);
    @(posedge clk); #1;
    in_i = '0; in_q = '0;
    repeat (d) @(posedge clk);
    if (d > 0) #1;
    upd_en = en;
    @(posedge clk); #1;
    upd_en = 1'b0; err_scale = '0; err_rot = '0;
    if (en) begin
      mr[a] = sat(mr[a] - (es >>> sh));
      mi[a] = sat(mi[a] - (er >>> sh));
    end
  endtask

  task automatic t_reset();
    chk("R1 reset valid", int'(out_valid), 0);
    chk("R1 reset out_i", int'(out_i), 0);
    chk("R1 reset out_q", int'(out_q), 0);
    fwd(1000, 0, "R1 unity entry 31");
    fwd(-500, 300, "R1 unity entry 18");
  endtask

  task automatic t_addr();
    upd(32, 0, 0, 512, 300, 1, 1'b1);
    fwd(32, 0, "R2 mag 32 axis");
    fwd(31, 0, "R2 mag 31 axis");
    fwd(20, 25, "R2 mag 32 diag");
    fwd(22, 22, "R2 mag 31 diag");
    fwd(-32, 0, "R2 negative axis");
    fwd(0, -40, "R2 negative q");
  endtask

  task automatic t_mult();
    upd(1000, -700, 0, 300, -800, 0, 1'b1);
    fwd(1000, -700, "R4 R3 mixed sign");
    fwd(-700, 1000, "R3 swapped");
    fwd(-1200, -300, "R3 third quadrant");
  endtask

  task automatic t_delay();
    upd(330, 0, 5, 1024, 512, 2, 1'b1);
    fwd(330, 0, "R5 delay 5 target");
    fwd(10, 0, "R5 entry 0 untouched");
    upd(650, 0, 63, -400, 64, 3, 1'b1);
    fwd(650, 0, "R5 delay 63 target");
    fwd(10, 0, "R5 entry 0 untouched 63");
  endtask

  task automatic t_sat();
    for (int n = 0; n < 3; n++) upd(-2048, 0, 0, 2047, -2047, 0, 1'b1);
    chk("R8 model low", mr[64], -2048);
    fwd(-2048, 0, "R8 R3 saturated gain and output");
    fwd(2047, 0, "R8 neighbour entry 63");
  endtask

  task automatic t_collide();
    int ei, eq;
    ei = sat((970 * mr[30]) >>> 11);
    eq = sat((970 * mi[30]) >>> 11);
    loop_dly = '0; mu_shift = 4'd0;
    in_valid = 1'b1; in_i = 12'sd970; in_q = '0;
    @(posedge clk); #1;
    in_valid = 1'b0; in_i = '0;
    upd_en = 1'b1; err_scale = 12'sd600; err_rot = -12'sd200;
    @(posedge clk); #1;
    upd_en = 1'b0; err_scale = '0; err_rot = '0;
    @(posedge clk); #1;
    chk("R6 old value out_i", int'(out_i), ei);
    chk("R6 old value out_q", int'(out_q), eq);
    mr[30] = sat(mr[30] - 600);
    mi[30] = sat(mi[30] + 200);
    fwd(970, 0, "R6 new value after");
  endtask

  task automatic t_idle();
    upd(970, 0, 0, -1500, 900, 0, 1'b0);
    fwd(970, 0, "R7 no write when disabled");
    upd(1000, -700, 3, 777, 777, 1, 1'b0);
    fwd(1000, -700, "R7 entry 38 unchanged");
  endtask

  initial begin
    for (int k = 0; k < 128; k++) begin mr[k] = 2047; mi[k] = 0; end
    #(CLK_PERIOD * 3 + 2);
    t_reset_during();
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    t_reset();
    t_addr();
    t_mult();
    t_delay();
    t_sat();
    t_collide();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic t_reset_during();
    chk("R1 in reset valid", int'(out_valid), 0);
    chk("R1 in reset out_i", int'(out_i), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule